// File: doc/BRIEF.md
# Simultaneous-Sampling Converter Bus Controller

This block is the host-side sequencer for a multi-channel converter that samples all of its channels at the same instant and returns the results over a shared parallel bus. A single start request runs one full cycle. The block shapes the conversion-start line for the selected acquisition mode, keeps the bus silent for a quiet interval before each sampling edge, and waits for the converter's busy flag to rise and then fall. It then reads the channels one after another with read strobes while chip select stays low.

Each captured word leaves the block with its channel number and a one-cycle valid pulse. A separate request writes a four-bit configuration word to the converter through a chip-select/write strobe, and bit 0 of that word chooses the acquisition mode. Every minimum interval is a time in nanoseconds, turned into whole clock cycles from a clock-frequency parameter.

Top module: `adc_bus_ctrl`

## Requirements
- R1: While reset is asserted and right after it, csN, rdN, wrN are high, convSt is high, busOe, busy, done and resValid are low.
- R2: A cfgWrite seen while idle drives csN and wrN low together with busOe high, with busOut carrying cfgValue in bits 3:0 and zeros above. Bit 0 of the written word is the mode bit used by every later conversion. A cfgWrite seen while busy is ignored: no write strobe appears and the mode is unchanged.
- R3: With mode bit 0, a start drives convSt low for max(acquisition, quiet) cycles, after which convSt rises (the sampling edge).
- R4: With mode bit 1, a start keeps convSt high for the quiet time and then drives it low for exactly the start-pulse cycles before it rises.
- R5: csN is high during at least the quiet-time cycles that come before every rising edge of convSt.
- R6: After the sampling edge, no read strobe begins until eoc has been seen high and then low.
- R7: The read burst has CHANNELS rdN low periods of exactly the read-low cycles each, separated by exactly the read-high cycles. csN stays low across the whole burst, and rdN is never low while eoc is high.
- R8: Each read produces one resValid pulse of one cycle, with resChan counting 0 to CHANNELS-1 in order and resData equal to the bus word presented during that read.
- R9: busy rises in the cycle after a start is accepted and stays high until done. done is a one-cycle pulse that comes after the last channel's result, in the same cycle that busy falls.
- R10: A start seen while busy is ignored: each accepted start yields exactly one sampling edge and CHANNELS results.
- R11: If cfgWrite and start arrive in the same idle cycle, the write is performed and the start is dropped.
- R12: Every interval in cycles equals the nanosecond minimum times CLK_HZ, rounded up to a whole cycle with a floor of one. This holds in particular for the write strobe length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one conversion-and-read cycle |
| cfgWrite | input | 1 | Request a configuration write |
| cfgValue | input | 4 | Configuration word; bit 0 selects the acquisition mode |
| busy | output | 1 | High while a write or conversion cycle is in progress |
| done | output | 1 | One-cycle pulse after the last channel result |
| convSt | output | 1 | Conversion-start line to the converter; rising edge samples |
| eoc | input | 1 | Converter end-of-conversion flag, high while converting |
| csN | output | 1 | Chip select, active low |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| busIn | input | DATA_W | Data bus as seen by the controller |
| busOut | output | DATA_W | Data bus value driven during a write |
| busOe | output | 1 | Bus output enable, high during a write |
| resData | output | DATA_W | Captured channel result |
| resChan | output | CH_W | Channel index of resData |
| resValid | output | 1 | One-cycle strobe marking resData/resChan |

## Verification
The bench builds the block with six channels, a 16-bit bus and a 50 MHz clock. With these values the acquisition low time (50 cycles) and the quiet time (25 cycles) differ, so mode 0 has to take the larger one, and the start pulse shrinks to a single cycle. Read and write strobes of two cycles place the capture point inside the low period rather than on an edge. A behavioural converter model with a random busy-flag latency and random per-channel words covers both modes, start and write requests that arrive while busy, and a write that collides with a start.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;

  localparam int unsigned CFG_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CFG,
    ST_QUIET,
    ST_ACQ,
    ST_WAIT_HI,
    ST_WAIT_LO,
    ST_RD_LO,
    ST_RD_HI
  } ctrlState_t;

  typedef struct packed {
    logic latchCfg;
    logic clrChan;
    logic capture;
    logic incChan;
  } ctrlStrobes_t;

  function automatic int unsigned nsToCycles(input longint unsigned ns,
                                             input longint unsigned hz);
    longint unsigned c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

  function automatic int unsigned maxOf(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_bus_ctrl_fsm.sv
module adc_bus_ctrl_fsm
  import adc_bus_pkg::*;
#(
  parameter int unsigned WR_CYC    = 2,
  parameter int unsigned QUIET_CYC = 25,
  parameter int unsigned PULSE_CYC = 1,
  parameter int unsigned LOW0_CYC  = 50,
  parameter int unsigned RDL_CYC   = 2,
  parameter int unsigned RDH_CYC   = 2,
  parameter int unsigned TMR_W     = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         cfgWrite,
  input  logic         eoc,
  input  logic         cfgMode,
  input  logic         lastChan,
  output ctrlStrobes_t stb,
  output logic         busy,
  output logic         done,
  output logic         convSt,
  output logic         csN,
  output logic         rdN,
  output logic         wrN,
  output logic         busOe
);

  localparam int unsigned RD_MID  = RDL_CYC / 2;
  localparam int unsigned MID_TMR = RDL_CYC - 1 - RD_MID;

  ctrlState_t state;
  logic [TMR_W-1:0] timer;
  logic timerZero;
  logic doneQ;

  assign timerZero = (timer == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      timer <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cfgWrite) begin
            state <= ST_CFG;
            timer <= TMR_W'(WR_CYC - 1);
          end else if (start) begin
            if (cfgMode) begin
              state <= ST_QUIET;
              timer <= TMR_W'(QUIET_CYC - 1);
            end else begin
              state <= ST_ACQ;
              timer <= TMR_W'(LOW0_CYC - 1);
            end
          end
        end
        ST_CFG: begin
          if (timerZero) state <= ST_IDLE;
          else           timer <= timer - 1'b1;
        end
        ST_QUIET: begin
          if (timerZero) begin
            state <= ST_ACQ;
            timer <= TMR_W'(PULSE_CYC - 1);
          end else begin
            timer <= timer - 1'b1;
          end
        end
        ST_ACQ: begin
          if (timerZero) state <= ST_WAIT_HI;
          else           timer <= timer - 1'b1;
        end
        ST_WAIT_HI: begin
          if (eoc) state <= ST_WAIT_LO;
        end
        ST_WAIT_LO: begin
          if (!eoc) begin
            state <= ST_RD_LO;
            timer <= TMR_W'(RDL_CYC - 1);
          end
        end
        ST_RD_LO: begin
          if (timerZero) begin
            if (lastChan) begin
              state <= ST_IDLE;
              doneQ <= 1'b1;
            end else begin
              state <= ST_RD_HI;
              timer <= TMR_W'(RDH_CYC - 1);
            end
          end else begin
            timer <= timer - 1'b1;
          end
        end
        ST_RD_HI: begin
          if (timerZero) begin
            state <= ST_RD_LO;
            timer <= TMR_W'(RDL_CYC - 1);
          end else begin
            timer <= timer - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.latchCfg = (state == ST_IDLE) && cfgWrite;
    stb.clrChan  = (state == ST_IDLE) && !cfgWrite && start;
    stb.capture  = (state == ST_RD_LO) && (timer == TMR_W'(MID_TMR));
    stb.incChan  = (state == ST_RD_LO) && timerZero && !lastChan;
  end

  always_comb begin
    busy   = (state != ST_IDLE);
    done   = doneQ;
    convSt = (state != ST_ACQ);
    wrN    = (state != ST_CFG);
    rdN    = (state != ST_RD_LO);
    csN    = !((state == ST_CFG) || (state == ST_RD_LO) || (state == ST_RD_HI));
    busOe  = (state == ST_CFG);
  end

endmodule

// File: rtl/adc_bus_ctrl_dp.sv
module adc_bus_ctrl_dp
  import adc_bus_pkg::*;
#(
  parameter int unsigned CHANNELS = 6,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CH_W     = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       stb,
  input  logic [CFG_W-1:0]   cfgValue,
  input  logic [DATA_W-1:0]  busIn,
  output logic               cfgMode,
  output logic               lastChan,
  output logic [DATA_W-1:0]  busOut,
  output logic [DATA_W-1:0]  resData,
  output logic [CH_W-1:0]    resChan,
  output logic               resValid
);

  logic [CFG_W-1:0] cfgReg;
  logic [CH_W-1:0]  chanIdx;

  always_ff @(posedge clk) begin
    if (!rstN) cfgReg <= '0;
    else if (stb.latchCfg) cfgReg <= cfgValue;
  end

  assign cfgMode = cfgReg[0];

  generate
    if (DATA_W > CFG_W) begin : g_pad
      assign busOut = {{(DATA_W - CFG_W){1'b0}}, cfgReg};
    end else begin : g_trunc
      assign busOut = cfgReg[DATA_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)            chanIdx <= '0;
    else if (stb.clrChan) chanIdx <= '0;
    else if (stb.incChan) chanIdx <= chanIdx + 1'b1;
  end

  assign lastChan = (chanIdx == CH_W'(CHANNELS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resData  <= '0;
      resChan  <= '0;
      resValid <= 1'b0;
    end else begin
      resValid <= stb.capture;
      if (stb.capture) begin
        resData <= busIn;
        resChan <= chanIdx;
      end
    end
  end

endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
  import adc_bus_pkg::*;
#(
  parameter int unsigned CHANNELS    = 6,
  parameter int unsigned DATA_W      = 16,
  parameter longint unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned ACQ_NS      = 1000,
  parameter int unsigned QUIET_NS    = 500,
  parameter int unsigned PULSE_NS    = 20,
  parameter int unsigned RD_LOW_NS   = 40,
  parameter int unsigned RD_HIGH_NS  = 40,
  parameter int unsigned WR_NS       = 40,
  localparam int unsigned CH_W       = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               cfgWrite,
  input  logic [3:0]         cfgValue,
  output logic               busy,
  output logic               done,
  output logic               convSt,
  input  logic               eoc,
  output logic               csN,
  output logic               rdN,
  output logic               wrN,
  input  logic [DATA_W-1:0]  busIn,
  output logic [DATA_W-1:0]  busOut,
  output logic               busOe,
  output logic [DATA_W-1:0]  resData,
  output logic [CH_W-1:0]    resChan,
  output logic               resValid
);

  localparam int unsigned ACQ_CYC   = nsToCycles(ACQ_NS, CLK_HZ);
  localparam int unsigned QUIET_CYC = nsToCycles(QUIET_NS, CLK_HZ);
  localparam int unsigned PULSE_CYC = nsToCycles(PULSE_NS, CLK_HZ);
  localparam int unsigned RDL_CYC   = nsToCycles(RD_LOW_NS, CLK_HZ);
  localparam int unsigned RDH_CYC   = nsToCycles(RD_HIGH_NS, CLK_HZ);
  localparam int unsigned WR_CYC    = nsToCycles(WR_NS, CLK_HZ);
  localparam int unsigned LOW0_CYC  = maxOf(ACQ_CYC, QUIET_CYC);
  localparam int unsigned MAX_CYC   = maxOf(maxOf(LOW0_CYC, PULSE_CYC),
                                      maxOf(maxOf(RDL_CYC, RDH_CYC), WR_CYC));
  localparam int unsigned TMR_W     = $clog2(MAX_CYC + 1);

  ctrlStrobes_t stb;
  logic cfgMode;
  logic lastChan;

  adc_bus_ctrl_fsm #(
    .WR_CYC   (WR_CYC),
    .QUIET_CYC(QUIET_CYC),
    .PULSE_CYC(PULSE_CYC),
    .LOW0_CYC (LOW0_CYC),
    .RDL_CYC  (RDL_CYC),
    .RDH_CYC  (RDH_CYC),
    .TMR_W    (TMR_W)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .cfgWrite(cfgWrite),
    .eoc     (eoc),
    .cfgMode (cfgMode),
    .lastChan(lastChan),
    .stb     (stb),
    .busy    (busy),
    .done    (done),
    .convSt  (convSt),
    .csN     (csN),
    .rdN     (rdN),
    .wrN     (wrN),
    .busOe   (busOe)
  );

  adc_bus_ctrl_dp #(
    .CHANNELS(CHANNELS),
    .DATA_W  (DATA_W),
    .CH_W    (CH_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .cfgValue(cfgValue),
    .busIn   (busIn),
    .cfgMode (cfgMode),
    .lastChan(lastChan),
    .busOut  (busOut),
    .resData (resData),
    .resChan (resChan),
    .resValid(resValid)
  );

endmodule

// File: rtl/adc_bus_ctrl_chk.sv
module adc_bus_ctrl_chk #(
  parameter int unsigned CHANNELS  = 6,
  parameter int unsigned CH_W      = 3,
  parameter int unsigned ACQ_CYC   = 50,
  parameter int unsigned QUIET_CYC = 25,
  parameter int unsigned PULSE_CYC = 1
) (
  input logic            clk,
  input logic            rstN,
  input logic            csN,
  input logic            rdN,
  input logic            wrN,
  input logic            convSt,
  input logic            eoc,
  input logic            busy,
  input logic            done,
  input logic            resValid,
  input logic [CH_W-1:0] resChan,
  input logic            cfgMode
);

  logic [15:0] sinceBus;
  logic [15:0] lowRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceBus <= '1;
      lowRun   <= '0;
    end else begin
      if (!csN) sinceBus <= '0;
      else if (sinceBus != '1) sinceBus <= sinceBus + 1'b1;
      if (convSt) lowRun <= '0;
      else if (lowRun != '1) lowRun <= lowRun + 1'b1;
    end
  end

  // R5
  quiet_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convSt) |-> (sinceBus >= 16'(QUIET_CYC)));

  // R3
  acq_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(convSt) && !cfgMode) |-> (lowRun >= 16'(ACQ_CYC)));

  // R4
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convSt) |-> (lowRun >= 16'(PULSE_CYC)));

  // R7
  rd_eoc_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> (!eoc && !csN));

  // R2
  no_wr_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> (rdN && convSt && !csN));

  // R9
  done_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  // R8
  chan_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (resChan < CH_W'(CHANNELS)));

endmodule

bind adc_bus_ctrl adc_bus_ctrl_chk #(
  .CHANNELS (CHANNELS),
  .CH_W     (CH_W),
  .ACQ_CYC  (ACQ_CYC),
  .QUIET_CYC(QUIET_CYC),
  .PULSE_CYC(PULSE_CYC)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .csN     (csN),
  .rdN     (rdN),
  .wrN     (wrN),
  .convSt  (convSt),
  .eoc     (eoc),
  .busy    (busy),
  .done    (done),
  .resValid(resValid),
  .resChan (resChan),
  .cfgMode (cfgMode)
);

// File: tb/test_adc_bus_ctrl.sv
module test_adc_bus_ctrl;

  localparam int CLK_PERIOD = 20;
  localparam int CHANNELS   = 6;
  localparam int DATA_W     = 16;
  localparam longint CLK_HZ = 50_000_000;
  localparam int CH_W       = 3;

  function automatic int cyc(input longint ns);
    longint c;
    c = (ns * CLK_HZ + 999_999_999) / 1_000_000_000;
    return (c < 1) ? 1 : int'(c);
  endfunction

  localparam int ACQ_C   = cyc(1000);
  localparam int QUIET_C = cyc(500);
  localparam int PULSE_C = cyc(20);
  localparam int RDL_C   = cyc(40);
  localparam int RDH_C   = cyc(40);
  localparam int WR_C    = cyc(40);

  function automatic int expLow(input bit mode);
    if (mode) return PULSE_C;
    return (ACQ_C > QUIET_C) ? ACQ_C : QUIET_C;
  endfunction

  logic clk = 0;
  logic rstN = 0;
  logic start = 0;
  logic cfgWrite = 0;
  logic [3:0] cfgValue = '0;
  logic busy, done, convSt, csN, rdN, wrN, busOe, resValid;
  logic eoc = 0;
  logic [DATA_W-1:0] busIn = '0;
  logic [DATA_W-1:0] busOut, resData;
  logic [CH_W-1:0] resChan;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_bus_ctrl #(.CHANNELS(CHANNELS), .DATA_W(DATA_W), .CLK_HZ(CLK_HZ)) i_adc_bus_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgWrite(cfgWrite), .cfgValue(cfgValue),
    .busy(busy), .done(done), .convSt(convSt), .eoc(eoc), .csN(csN), .rdN(rdN),
    .wrN(wrN), .busIn(busIn), .busOut(busOut), .busOe(busOe), .resData(resData),
    .resChan(resChan), .resValid(resValid)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // converter model
  logic [DATA_W-1:0] samples [CHANNELS];
  int readIdx = 0;
  initial begin
    logic pConv, pRd;
    int lat;
    pConv = 1; pRd = 1; lat = 0;
    forever begin
      @(negedge clk);
      if (convSt && !pConv) begin
        for (int i = 0; i < CHANNELS; i++) samples[i] = DATA_W'($urandom);
        readIdx = 0;
        eoc = 1;
        lat = 2 + ($urandom % 19);
      end else if (eoc) begin
        if (lat == 0) eoc = 0;
        else lat--;
      end
      if (rdN && !pRd) readIdx++;
      if (!csN && !rdN && readIdx < CHANNELS) busIn = samples[readIdx];
      else busIn = DATA_W'(16'h5A5A);
      pConv = convSt;
      pRd = rdN;
    end
  end

  // monitor
  bit expMode = 0;
  logic [3:0] expCfg = '0;
  int rises = 0, results = 0, writes = 0;
  initial begin
    logic pConv, pRd, pWr, pBusy;
    int lowLen, sinceBus, rdLow, rdHigh, wrLen, rdCount, resIdx;
    bit sawHi, eocDone, csGap;
    pConv = 1; pRd = 1; pWr = 1; pBusy = 0;
    lowLen = 0; sinceBus = 1000; rdLow = 0; rdHigh = 0; wrLen = 0;
    rdCount = 0; resIdx = 0; sawHi = 0; eocDone = 0; csGap = 0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (!convSt) lowLen++;
        else if (!pConv) begin
          chk(lowLen == expLow(expMode), expMode ? "R4 pulse length" : "R3 acquisition length",
              lowLen, expLow(expMode));
          chk(sinceBus >= QUIET_C, "R5 quiet cycles before edge", sinceBus, QUIET_C);
          rises++; lowLen = 0; sawHi = 0; eocDone = 0; rdCount = 0; resIdx = 0; csGap = 0;
        end
        if (eoc) sawHi = 1;
        else if (sawHi) eocDone = 1;
        if (!rdN) begin
          if (pRd) begin
            chk(eocDone, "R6 read after eoc fall", eocDone, 1);
            if (rdCount > 0) begin
              chk(rdHigh == RDH_C, "R7 read high gap", rdHigh, RDH_C);
              chk(!csGap, "R7 csN low across burst", csGap, 0);
            end
          end
          rdLow++;
        end else if (!pRd) begin
          chk(rdLow == RDL_C, "R7 read low width", rdLow, RDL_C);
          rdLow = 0; rdHigh = 1; rdCount++;
        end else begin
          rdHigh++;
          if (rdCount > 0 && rdCount < CHANNELS && csN) csGap = 1;
        end
        if (!wrN) begin
          if (pWr) chk(busOe && busOut == DATA_W'(expCfg), "R2 write bus value", busOut, expCfg);
          wrLen++;
        end else if (!pWr) begin
          chk(wrLen == WR_C, "R12 write strobe cycles", wrLen, WR_C);
          writes++; wrLen = 0;
        end
        if (resValid) begin
          chk(resChan == CH_W'(resIdx), "R8 channel order", resChan, resIdx);
          chk(resData == samples[resIdx % CHANNELS], "R8 result data", resData,
              samples[resIdx % CHANNELS]);
          resIdx++; results++;
        end
        if (done) begin
          chk(resIdx == CHANNELS && pBusy && !busy, "R9 done after last result", resIdx, CHANNELS);
        end
        if (!csN) sinceBus = 0;
        else sinceBus++;
      end
      pConv = convSt; pRd = rdN; pWr = wrN; pBusy = busy;
    end
  end

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic doWrite(input logic [3:0] v);
    int w0;
    w0 = writes;
    expCfg = v;
    @(negedge clk);
    cfgValue = v; cfgWrite = 1;
    @(negedge clk);
    cfgWrite = 0;
    waitIdle();
    expMode = v[0];
    chk(writes == w0 + 1, "R2 one write strobe", writes, w0 + 1);
  endtask

  task automatic doConv();
    int r0, n0;
    r0 = rises; n0 = results;
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy, "R9 busy after start", busy, 1);
    waitIdle();
    repeat (3) @(negedge clk);
    chk(rises == r0 + 1, "R10 one edge per start", rises, r0 + 1);
    chk(results == n0 + CHANNELS, "R8 results per start", results, n0 + CHANNELS);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(csN && rdN && wrN && convSt && !busOe && !busy && !done && !resValid,
        "R1 pins during reset", {csN, rdN, wrN, convSt, busOe, busy}, 6'b111100);
    rstN = 1;
    @(negedge clk);
    chk(csN && rdN && wrN && convSt && !busy && !resValid, "R1 pins after reset",
        {csN, rdN, wrN, convSt}, 4'b1111);

    // mode 0 default
    doConv();
    doWrite(4'b0001);
    doConv();
    doWrite(4'b1010);
    doConv();

    // R10: start while busy is ignored
    begin
      int r0, n0;
      r0 = rises; n0 = results;
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
      repeat (10) @(negedge clk);
      start = 1;
      @(negedge clk); start = 0;
      waitIdle();
      repeat (100) @(negedge clk);
      chk(rises == r0 + 1, "R10 busy start ignored (edges)", rises, r0 + 1);
      chk(results == n0 + CHANNELS, "R10 busy start ignored (results)", results, n0 + CHANNELS);
    end

    // R2: write while busy is ignored; mode must remain 0
    begin
      int w0;
      w0 = writes;
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
      repeat (5) @(negedge clk);
      cfgValue = 4'hF; cfgWrite = 1;
      @(negedge clk); cfgWrite = 0;
      waitIdle();
      repeat (3) @(negedge clk);
      chk(writes == w0, "R2 busy write ignored", writes, w0);
      doConv();
    end

    // R11: write and start together
    begin
      int r0, w0;
      r0 = rises; w0 = writes;
      expCfg = 4'b0011;
      @(negedge clk);
      cfgValue = 4'b0011; cfgWrite = 1; start = 1;
      @(negedge clk);
      cfgWrite = 0; start = 0;
      waitIdle();
      repeat (100) @(negedge clk);
      expMode = 1;
      chk(writes == w0 + 1, "R11 write performed", writes, w0 + 1);
      chk(rises == r0, "R11 start dropped", rises, r0);
      doConv();
    end

    // random mix
    for (int it = 0; it < 14; it++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[0]) doWrite(r[4:1]);
      repeat (r[9:5]) @(negedge clk);
      doConv();
    end

    finishRun();
  end

endmodule